// File: doc/BRIEF.md
# Unequal-Protection Two-Bit-Redundancy Codec

This block protects a 32-bit word with only two extra stored bits. It maps the word to a 34-bit codeword. Words whose six most significant bits are all zero form a favoured class. A single flipped bit in a favoured word's codeword is repaired. For every other word, a single flipped bit is only detected. The codeword has three parts:

- a 33-bit linear part, which always has even weight;
- a class flag bit;
- inside the linear part, a 26-bit data field, a 6-bit check field and a parity bit.

The check field comes from division by the polynomial 1 + x + x^6, so the favoured class forms an extended, shortened cyclic Hamming subcode. A word outside the favoured class also shifts the check field and the parity bit by a fixed pattern that depends on its six leading bits. The decoder can therefore recover those six bits from the linear part alone, without reading the flag.

The encoder is combinational. The decoder registers its result and returns a status and the recovered word one clock after a codeword is presented with its valid strobe. A memory controller places the encoder on its write path and the decoder on its read path. On a status of uncorrectable, the controller raises an error instead of using the data.

Top module: `upp_codec`

## Requirements
- R1: Codeword bits [25:0] always equal message bits [25:0].
- R2: Codeword bit 33 (the class flag) is the OR of message bits [31:26]. It is 0 exactly when the message is favoured.
- R3: The check field is set as follows. Let h be the remainder of (message[25:0] as a polynomial, bit i the coefficient of x^i) multiplied by x^6 and divided by 1+x+x^6; h goes into bits [31:26], with h bit j in codeword bit 26+j. Bit 32 makes bits [32:0] even weight. For each set message bit 26+j (j = 0..5), codeword bits 26+j and 27+j are then both inverted.
- R4: dec_valid_o equals dec_valid_i delayed by exactly one clock.
- R5: A received word whose bits [32:0] have even weight gets status 2'b00 (clean), and its message is recovered from bits [32:0]. Every unaltered codeword returns its original message.
- R6: A single flipped bit anywhere in bits [32:0] of a favoured codeword gets status 2'b01 (corrected) and returns the original message.
- R7: A received word with odd-weight bits [32:0] and flag bit 1 gets status 2'b10 (uncorrectable), with message output 0. A single flipped bit in bits [32:0] of a non-favoured codeword therefore gets this status.
- R8: A received word with odd-weight bits [32:0], flag bit 0, and a syndrome (check field XOR the check field recomputed from bits [25:0]) that is neither zero, nor a single set bit, nor the column of one of the 26 data positions, gets status 2'b10 with message output 0.
- R9: After reset, dec_valid_o, dec_status_o and dec_msg_o are all 0.
- R10: A flip of the flag bit alone on any codeword gets status 2'b00 and returns the original message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_msg_i | input | 32 | Message to encode |
| enc_cw_o | output | 34 | Codeword (combinational) |
| dec_valid_i | input | 1 | Received codeword is present |
| dec_cw_i | input | 34 | Received codeword |
| dec_valid_o | output | 1 | Decode result is valid |
| dec_msg_o | output | 32 | Recovered message |
| dec_status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
The encoder output is combinational. It is sampled a short delay after the message changes, within the same cycle. A decode result appears one register stage after the strobe. The bench drives a codeword on a falling edge and reads status and message on the next falling edge, which is the first point after the capturing rising edge. One falling edge later, it confirms that the valid output has dropped. Every one of the 34 single-bit flips is swept for each favoured and non-favoured test word. Received words whose syndromes fall on unused Hamming columns are built separately.

// File: rtl/upp_pkg.sv
package upp_pkg;
  parameter int MSG_W  = 32;
  parameter int LEAD_W = 6;
  localparam int DATA_W = MSG_W - LEAD_W;
  localparam int CHK_W  = LEAD_W;
  localparam int LIN_W  = DATA_W + CHK_W + 1;
  localparam int CW_W   = LIN_W + 1;
  localparam int MAX_SHIFT = 2 ** CHK_W;
  // low taps of the generator x^6 + x + 1
  localparam logic [CHK_W-1:0] GEN_TAPS = 6'b000011;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FAIL  = 2'b10
  } status_e;

  // x^(pos+CHK_W) mod g: syndrome of a flip in data position pos
  function automatic logic [CHK_W-1:0] pos_column(input int pos);
    logic [CHK_W-1:0] r;
    r = {{(CHK_W-1){1'b0}}, 1'b1};
    for (int s = 0; s < MAX_SHIFT; s++) begin
      if (s < pos + CHK_W)
        r = {r[CHK_W-2:0], 1'b0} ^ (r[CHK_W-1] ? GEN_TAPS : '0);
    end
    return r;
  endfunction

  function automatic logic [CHK_W-1:0] check_bits(input logic [DATA_W-1:0] u);
    logic [CHK_W-1:0] h;
    h = '0;
    for (int i = 0; i < DATA_W; i++)
      if (u[i]) h ^= pos_column(i);
    return h;
  endfunction

  // fold of the leading bits onto check+parity positions (two bits per lead bit)
  function automatic logic [CHK_W:0] lead_fold(input logic [LEAD_W-1:0] a);
    logic [CHK_W:0] f;
    f = '0;
    for (int j = 0; j < LEAD_W; j++)
      if (a[j]) f ^= ((CHK_W+1)'(3) << j);
    return f;
  endfunction
endpackage

// File: rtl/upp_encoder.sv
module upp_encoder
  import upp_pkg::*;
(
  input  logic [MSG_W-1:0] msg_i,
  output logic [CW_W-1:0]  cw_o
);
  logic [DATA_W-1:0] data_w;
  logic [LEAD_W-1:0] lead_w;
  logic [CHK_W-1:0]  chk_w;
  logic              par_w;
  logic [CHK_W:0]    fold_w;

  assign data_w = msg_i[DATA_W-1:0];
  assign lead_w = msg_i[MSG_W-1:DATA_W];
  assign chk_w  = check_bits(data_w);
  assign par_w  = ^{data_w, chk_w};
  assign fold_w = lead_fold(lead_w);
  assign cw_o   = {|lead_w, ({par_w, chk_w} ^ fold_w), data_w};
endmodule

// File: rtl/upp_dec_core.sv
module upp_dec_core
  import upp_pkg::*;
(
  input  logic [CW_W-1:0]  cw_i,
  output logic [MSG_W-1:0] msg_o,
  output status_e          status_o,
  output logic             odd_o,
  output logic             hit_o,
  output logic [CHK_W-1:0] syn_o
);
  logic [DATA_W-1:0] data_r;
  logic [CHK_W-1:0]  chk_r, chk_c;
  logic              par_r, par_c, flag_r;
  logic [CHK_W:0]    diff_w;
  logic [LEAD_W-1:0] lead_w;
  logic [DATA_W-1:0] fix_mask;
  logic              data_hit, chk_hit, par_hit;

  assign data_r = cw_i[DATA_W-1:0];
  assign chk_r  = cw_i[DATA_W+CHK_W-1:DATA_W];
  assign par_r  = cw_i[LIN_W-1];
  assign flag_r = cw_i[CW_W-1];
  assign chk_c  = check_bits(data_r);
  assign par_c  = ^{data_r, chk_c};
  assign odd_o  = ^cw_i[LIN_W-1:0];
  assign syn_o  = chk_r ^ chk_c;
  assign diff_w = {par_r, chk_r} ^ {par_c, chk_c};

  // undo the fold: lead bit j is the XOR of diff bits 0..j
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < LEAD_W; j++) begin
      acc = acc ^ diff_w[j];
      lead_w[j] = acc;
    end
  end

  always_comb begin
    fix_mask = '0;
    data_hit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (syn_o == pos_column(i)) begin
        fix_mask[i] = 1'b1;
        data_hit    = 1'b1;
      end
    end
  end

  assign chk_hit = $onehot(syn_o);
  assign par_hit = (syn_o == '0);
  assign hit_o   = data_hit | chk_hit | par_hit;

  always_comb begin
    if (!odd_o) begin
      status_o = ST_CLEAN;
      msg_o    = {lead_w, data_r};
    end else if (!flag_r && hit_o) begin
      status_o = ST_FIXED;
      msg_o    = {{LEAD_W{1'b0}}, data_r ^ fix_mask};
    end else begin
      status_o = ST_FAIL;
      msg_o    = '0;
    end
  end
endmodule

// File: rtl/upp_codec.sv
module upp_codec
  import upp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MSG_W-1:0]  enc_msg_i,
  output logic [CW_W-1:0]   enc_cw_o,
  input  logic              dec_valid_i,
  input  logic [CW_W-1:0]   dec_cw_i,
  output logic              dec_valid_o,
  output logic [MSG_W-1:0]  dec_msg_o,
  output logic [1:0]        dec_status_o
);
  logic [MSG_W-1:0] core_msg_w;
  status_e          core_status_w;
  logic             core_odd_w;
  logic             core_hit_w;
  logic [CHK_W-1:0] core_syn_w;

  upp_encoder u_enc (
    .msg_i (enc_msg_i),
    .cw_o  (enc_cw_o)
  );

  upp_dec_core u_dec (
    .cw_i     (dec_cw_i),
    .msg_o    (core_msg_w),
    .status_o (core_status_w),
    .odd_o    (core_odd_w),
    .hit_o    (core_hit_w),
    .syn_o    (core_syn_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o  <= 1'b0;
      dec_msg_o    <= '0;
      dec_status_o <= ST_CLEAN;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_msg_o    <= core_msg_w;
        dec_status_o <= core_status_w;
      end
    end
  end
endmodule

// File: rtl/upp_codec_chk.sv
module upp_codec_chk
  import upp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MSG_W-1:0]  enc_msg_i,
  input logic [CW_W-1:0]   enc_cw_o,
  input logic              dec_valid_i,
  input logic [CW_W-1:0]   dec_cw_i,
  input logic              dec_valid_o,
  input logic [MSG_W-1:0]  dec_msg_o,
  input logic [1:0]        dec_status_o,
  input logic              core_odd_w,
  input logic              core_hit_w,
  input logic [CHK_W-1:0]  core_syn_w
);
  // R1
  data_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_cw_o[DATA_W-1:0] == enc_msg_i[DATA_W-1:0]);
  // R2
  class_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_cw_o[CW_W-1] == (enc_msg_i[MSG_W-1:DATA_W] != '0));
  // R3
  even_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(^enc_cw_o[LIN_W-1:0]));
  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> dec_valid_o);
  // R4
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> !dec_valid_o);
  // R5
  even_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i && !(^dec_cw_i[LIN_W-1:0]) |=> dec_status_o == 2'b00);
  // R6
  fixed_favoured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o && dec_status_o == 2'b01 |-> dec_msg_o[MSG_W-1:DATA_W] == '0);
  // R7
  flag_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i && (^dec_cw_i[LIN_W-1:0]) && dec_cw_i[CW_W-1]
      |=> dec_status_o == 2'b10 && dec_msg_o == '0);
  // R8
  nomatch_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i && core_odd_w && !dec_cw_i[CW_W-1] && !core_hit_w
      |=> dec_status_o == 2'b10);
  // R8
  syn_zero_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i && core_syn_w == '0 && !core_odd_w |=> dec_status_o != 2'b10);
endmodule

bind upp_codec upp_codec_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enc_msg_i    (enc_msg_i),
  .enc_cw_o     (enc_cw_o),
  .dec_valid_i  (dec_valid_i),
  .dec_cw_i     (dec_cw_i),
  .dec_valid_o  (dec_valid_o),
  .dec_msg_o    (dec_msg_o),
  .dec_status_o (dec_status_o),
  .core_odd_w   (core_odd_w),
  .core_hit_w   (core_hit_w),
  .core_syn_w   (core_syn_w)
);

// File: tb/upp_codec_bench.sv
module upp_codec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] enc_msg_i = '0;
  logic [33:0] enc_cw_o;
  logic        dec_valid_i = 1'b0;
  logic [33:0] dec_cw_i = '0;
  logic        dec_valid_o;
  logic [31:0] dec_msg_o;
  logic [1:0]  dec_status_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  upp_codec u_upp_codec (
    .clk(clk), .rst_n(rst_n), .enc_msg_i(enc_msg_i), .enc_cw_o(enc_cw_o),
    .dec_valid_i(dec_valid_i), .dec_cw_i(dec_cw_i), .dec_valid_o(dec_valid_o),
    .dec_msg_o(dec_msg_o), .dec_status_o(dec_status_o)
  );

  // x^k mod (1+x+x^6) by long division of a single-term polynomial
  function automatic logic [5:0] ref_rem(input int k);
    logic [63:0] p;
    p = 64'd1 << k;
    for (int d = 63; d >= 6; d--)
      if (p[d]) p ^= (64'h43 << (d - 6));
    return p[5:0];
  endfunction

  function automatic logic [33:0] ref_encode(input logic [31:0] m);
    logic [32:0] lin;
    logic [5:0]  h;
    h = '0;
    for (int i = 0; i < 26; i++) if (m[i]) h ^= ref_rem(i + 6);
    lin = {^{m[25:0], h}, h, m[25:0]};
    for (int j = 0; j < 6; j++) if (m[26+j]) lin ^= (33'b11 << (26 + j));
    return {m[31:26] != 6'd0, lin};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_decode(input logic [33:0] cw, input logic [1:0] st,
                            input logic [31:0] msg, input string req);
    @(negedge clk);
    dec_cw_i = cw;
    dec_valid_i = 1'b1;
    @(negedge clk);
    dec_valid_i = 1'b0;
    check(dec_valid_o == 1'b1, "R4", "valid after one clock", 64'(dec_valid_o), 64'd1);
    check(dec_status_o == st, req, "status", 64'(dec_status_o), 64'(st));
    check(dec_msg_o == msg, req, "message", 64'(dec_msg_o), 64'(msg));
  endtask

  logic [31:0] msgs [12];

  initial begin
    msgs[0] = 32'h0000_0000; msgs[1] = 32'h03FF_FFFF; msgs[2] = 32'h0000_0001;
    msgs[3] = 32'h0255_AA5A; msgs[4] = 32'h0200_0000; msgs[5] = 32'h0123_4567;
    msgs[6] = 32'hFFFF_FFFF; msgs[7] = 32'h0400_0000; msgs[8] = 32'h8000_0000;
    msgs[9] = 32'hFC00_0000; msgs[10] = 32'h5A5A_5A5A; msgs[11] = 32'h2BCD_1234;

    #3;
    // R9 reset state
    check(dec_valid_o == 1'b0, "R9", "valid in reset", 64'(dec_valid_o), 64'd0);
    check(dec_status_o == 2'b00, "R9", "status in reset", 64'(dec_status_o), 64'd0);
    check(dec_msg_o == 32'd0, "R9", "message in reset", 64'(dec_msg_o), 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dec_valid_o == 1'b0, "R9", "valid after reset", 64'(dec_valid_o), 64'd0);

    for (int t = 0; t < 12; t++) begin
      logic [33:0] exp_cw;
      bit fav;
      exp_cw = ref_encode(msgs[t]);
      fav = (msgs[t][31:26] == 6'd0);
      @(negedge clk);
      enc_msg_i = msgs[t];
      #1;
      check(enc_cw_o[25:0] == msgs[t][25:0], "R1", "data field", 64'(enc_cw_o), 64'(exp_cw));
      check(enc_cw_o[33] == !fav, "R2", "class flag", 64'(enc_cw_o), 64'(exp_cw));
      check(enc_cw_o == exp_cw, "R3", "codeword", 64'(enc_cw_o), 64'(exp_cw));
      run_decode(exp_cw, 2'b00, msgs[t], "R5");
      @(negedge clk);
      check(dec_valid_o == 1'b0, "R4", "valid drops", 64'(dec_valid_o), 64'd0);
      for (int b = 0; b < 34; b++) begin
        logic [33:0] bad;
        bad = exp_cw ^ (34'd1 << b);
        if (b == 33)
          run_decode(bad, 2'b00, msgs[t], "R10");
        else if (fav)
          run_decode(bad, 2'b01, msgs[t], "R6");
        else
          run_decode(bad, 2'b10, 32'd0, "R7");
      end
    end

    // R8: syndromes on Hamming columns beyond the 26 used data positions
    for (int c = 26; c < 57; c += 6) begin
      logic [25:0] u;
      logic [5:0]  h;
      logic [33:0] rx;
      u = 26'h15A_C3F ^ 26'(c);
      h = '0;
      for (int i = 0; i < 26; i++) if (u[i]) h ^= ref_rem(i + 6);
      h ^= ref_rem(c + 6);
      rx = {1'b0, ~(^{u, h}), h, u};
      run_decode(rx, 2'b10, 32'd0, "R8");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule